// File: doc/BRIEF.md
# PCI Type 0 configuration address translator

This block sits behind a CPU-side window reserved for configuration cycles to devices on the local PCI bus. Each access into the window carries a 16-bit offset and a byte size. The block joins the offset with the low half of a software-held map value to form a 32-bit intermediate address. It then rewrites that address into a Type 0 configuration address: the bus number, a device number, the function, the dword register index and the enable bit.

The device number is not a binary field. The upper bits of the intermediate address form a one-hot select vector, and the device number is the position of its lowest set bit. The translation itself is combinational. Its outcome is captured in registers on each access strobe.

A successful translation raises a valid flag and a one-cycle pulse that tells the host bridge to clear its received-abort status bits. The block raises other flags instead in these cases:
- the map value marks the access as unsupported;
- the select vector is empty;
- the byte size is illegal.

An unsupported read also returns an all-ones fill pattern that matches the access size.

Top module: `pcicfg_xlat`

## Requirements
- R1: The intermediate address is {map_cfg[15:0], acc_off[15:0]}. The device number is the index (0 to 20) of the lowest set bit of intermediate bits [31:11], so with several bits set the lowest one wins.
- R2: A translated address has these fields:
  - bit 31 = 1;
  - bits [30:24] = 0;
  - bits [23:16] = bus_num as sampled with the strobe;
  - bits [15:11] = device number;
  - bits [10:8] = intermediate [10:8];
  - bits [7:2] = intermediate [7:2];
  - bits [1:0] = 0.
- R3: Results appear on the outputs in the cycle after acc_vld is sampled high. Back-to-back strobes give back-to-back results. cfg_vld, cfg_err, cfg_unsup and abort_clr are high for one cycle per access, at most one of the first three at a time. All four are low in cycles with no result.
- R4: With a legal size, map_cfg[16] = 1 makes the access unsupported. cfg_unsup is raised, cfg_vld, cfg_err and abort_clr stay low, and cfg_addr keeps its previous value. This drops the write.
- R5: rd_fill is loaded on every access and holds between accesses. For an unsupported read it is 0x000000FF (size 1), 0x0000FFFF (size 2) or 0xFFFFFFFF (size 4). For every other access it is 0.
- R6: When intermediate bits [31:11] are all zero, cfg_err is raised instead of cfg_vld, and cfg_addr keeps its previous value.
- R7: abort_clr pulses exactly with each translated access (cfg_vld) and never with an error or an unsupported access.
- R8: Only acc_size values 1, 2 and 4 are accepted. Any other value raises cfg_err, and this check takes priority over the unsupported check. cfg_unsup stays low, rd_fill becomes 0 and cfg_addr is held.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 16 | Offset of the access inside the window |
| acc_size | input | 3 | Access size in bytes |
| map_cfg | input | 17 | Map value: [15:0] upper address half, [16] unsupported-cycle flag |
| bus_num | input | 8 | Bus number placed into the translated address |
| cfg_addr | output | 32 | Last translated configuration address |
| cfg_vld | output | 1 | Translation succeeded for the last access |
| cfg_err | output | 1 | Empty select vector or illegal size |
| cfg_unsup | output | 1 | Access was unsupported |
| rd_fill | output | 32 | All-ones read return for unsupported reads |
| abort_clr | output | 1 | Pulse to clear received master/target abort status |

## Verification
A fault in the select-vector encoder appears as a wrong device field on cfg_addr in the cycle after the strobe. A fault in the outcome decode appears in that same cycle as the wrong flag, a stray abort_clr pulse, or a cfg_addr that moved when it should have held. A stuck output register would show in the idle cycles after an access, because the pulses must return low and the held address and fill must stay unchanged. The stimulus covers:
- select bits from the offset alone and from the map alone;
- several select bits set at once;
- every legal and illegal size, with and without the unsupported flag.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int CFG_AW     = 32;
  localparam int LOW_W      = 16;
  localparam int UNSUP_BIT  = 16;
  localparam int MAP_W      = UNSUP_BIT + 1;
  localparam int SEL_LSB    = 11;
  localparam int SEL_W      = CFG_AW - SEL_LSB;
  localparam int IDX_W      = $clog2(SEL_W);
  localparam int DEV_W      = 5;
  localparam int DEV_LSB    = 11;
  localparam int BUS_W      = 8;
  localparam int BUS_LSB    = 16;
  localparam int FN_W       = 3;
  localparam int FN_LSB     = 8;
  localparam int REG_W      = 6;
  localparam int REG_LSB    = 2;
  localparam int EN_BIT     = 31;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int SIZE_W     = 3;

  typedef struct packed {
    logic [CFG_AW-1:0] addr;
    logic              ok;
    logic              err;
    logic              unsup;
    logic [DATA_W-1:0] fill;
  } xlat_res_t;
endpackage

// File: rtl/pcicfg_rst_sync.sv
module pcicfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pcicfg_lsb_enc.sv
module pcicfg_lsb_enc #(
  parameter int W  = 21,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [W:0]   none_below;
  logic [W-1:0] hit;

  assign none_below[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_lane
      assign hit[g]          = bits_i[g] & none_below[g];
      assign none_below[g+1] = none_below[g] & ~bits_i[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = ~none_below[W];
endmodule

// File: rtl/pcicfg_fill.sv
module pcicfg_fill #(
  parameter int NB = 4,
  parameter int SW = 3
) (
  input  logic [SW-1:0]   size_i,
  output logic            legal_o,
  output logic [8*NB-1:0] mask_o
);
  localparam int NPOW = $clog2(NB) + 1;

  logic [NPOW-1:0] pow_hit;

  genvar g;
  generate
    for (g = 0; g < NPOW; g++) begin : g_pow
      assign pow_hit[g] = (size_i == SW'(1 << g));
    end
    for (g = 0; g < NB; g++) begin : g_lane
      assign mask_o[8*g +: 8] = {8{legal_o && (32'(size_i) > g)}};
    end
  endgenerate

  assign legal_o = |pow_hit;
endmodule

// File: rtl/pcicfg_xlat_core.sv
module pcicfg_xlat_core
  import pcicfg_pkg::*;
(
  input  logic [LOW_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wr_i,
  input  logic [MAP_W-1:0]  map_i,
  input  logic [BUS_W-1:0]  bus_i,
  output xlat_res_t         res_o
);
  localparam int DEV_MAX = (1 << DEV_W) - 1;

  logic [CFG_AW-1:0] inter;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  dev_idx;
  logic              sel_any;
  logic              dev_over;
  logic              size_ok;
  logic [DATA_W-1:0] size_mask;
  logic              unused_lo;

  assign inter     = {map_i[LOW_W-1:0], off_i};
  assign sel       = inter[CFG_AW-1:SEL_LSB];
  assign unused_lo = ^inter[REG_LSB-1:0];

  pcicfg_lsb_enc #(.W(SEL_W), .IW(IDX_W)) u_enc (
    .bits_i (sel),
    .idx_o  (dev_idx),
    .any_o  (sel_any)
  );

  pcicfg_fill #(.NB(DATA_BYTES), .SW(SIZE_W)) u_fill (
    .size_i  (size_i),
    .legal_o (size_ok),
    .mask_o  (size_mask)
  );

  assign dev_over = int'(dev_idx) > DEV_MAX;

  always_comb begin
    res_o = '0;
    if (!size_ok) begin
      res_o.err = 1'b1;
    end else if (map_i[UNSUP_BIT]) begin
      res_o.unsup = 1'b1;
      res_o.fill  = wr_i ? '0 : size_mask;
    end else if (!sel_any || dev_over) begin
      res_o.err = 1'b1;
    end else begin
      res_o.ok                      = 1'b1;
      res_o.addr[EN_BIT]            = 1'b1;
      res_o.addr[BUS_LSB +: BUS_W]  = bus_i;
      res_o.addr[DEV_LSB +: DEV_W]  = DEV_W'(dev_idx);
      res_o.addr[FN_LSB +: FN_W]    = inter[FN_LSB +: FN_W];
      res_o.addr[REG_LSB +: REG_W]  = inter[REG_LSB +: REG_W];
    end
  end
endmodule

// File: rtl/pcicfg_xlat.sv
module pcicfg_xlat
  import pcicfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [LOW_W-1:0]  acc_off,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [MAP_W-1:0]  map_cfg,
  input  logic [BUS_W-1:0]  bus_num,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic              cfg_vld,
  output logic              cfg_err,
  output logic              cfg_unsup,
  output logic [DATA_W-1:0] rd_fill,
  output logic              abort_clr
);
  logic      srst_n;
  xlat_res_t res;

  logic              addr_en, fill_en;
  logic              vld_d, err_d, unsup_d, clr_d;
  logic [CFG_AW-1:0] addr_q;
  logic [DATA_W-1:0] fill_q;
  logic              vld_q, err_q, unsup_q, clr_q;

  pcicfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pcicfg_xlat_core u_core (
    .off_i  (acc_off),
    .size_i (acc_size),
    .wr_i   (acc_wr),
    .map_i  (map_cfg),
    .bus_i  (bus_num),
    .res_o  (res)
  );

  always_comb begin
    addr_en = acc_vld & res.ok;
    fill_en = acc_vld;
    vld_d   = acc_vld & res.ok;
    err_d   = acc_vld & res.err;
    unsup_d = acc_vld & res.unsup;
    clr_d   = acc_vld & res.ok;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      unsup_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      err_q   <= err_d;
      unsup_q <= unsup_d;
      clr_q   <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= res.addr;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= res.fill;
    end
  end

  assign cfg_addr  = addr_q;
  assign cfg_vld   = vld_q;
  assign cfg_err   = err_q;
  assign cfg_unsup = unsup_q;
  assign rd_fill   = fill_q;
  assign abort_clr = clr_q;
endmodule

// File: rtl/pcicfg_xlat_chk.sv
module pcicfg_xlat_chk
  import pcicfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic [BUS_W-1:0]  bus_num,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic              cfg_vld,
  input logic              cfg_err,
  input logic              cfg_unsup,
  input logic [DATA_W-1:0] rd_fill,
  input logic              abort_clr
);
  // R3
  result_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_vld || cfg_err || cfg_unsup) |-> $past(acc_vld));

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_vld, cfg_err, cfg_unsup}));

  // R2
  addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vld |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0 && cfg_addr[1:0] == 2'd0));

  // R2
  bus_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vld |-> (cfg_addr[23:16] == $past(bus_num)));

  // R4
  addr_hold_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unsup |-> $stable(cfg_addr));

  // R6
  addr_hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(cfg_addr));

  // R7
  clr_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err || cfg_unsup) |-> !abort_clr);

  // R5
  fill_only_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld ##1 (rd_fill != '0)) |-> cfg_unsup);
endmodule

bind pcicfg_xlat pcicfg_xlat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_vld   (acc_vld),
  .bus_num   (bus_num),
  .cfg_addr  (cfg_addr),
  .cfg_vld   (cfg_vld),
  .cfg_err   (cfg_err),
  .cfg_unsup (cfg_unsup),
  .rd_fill   (rd_fill),
  .abort_clr (abort_clr)
);

// File: tb/sim_pcicfg_xlat.sv
`timescale 1ns/1ps
module sim_pcicfg_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld;
  logic        acc_wr;
  logic [15:0] acc_off;
  logic [2:0]  acc_size;
  logic [16:0] map_cfg;
  logic [7:0]  bus_num;
  logic [31:0] cfg_addr;
  logic        cfg_vld, cfg_err, cfg_unsup, abort_clr;
  logic [31:0] rd_fill;

  always #4 clk = ~clk;

  pcicfg_xlat u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_off(acc_off), .acc_size(acc_size), .map_cfg(map_cfg),
    .bus_num(bus_num), .cfg_addr(cfg_addr), .cfg_vld(cfg_vld),
    .cfg_err(cfg_err), .cfg_unsup(cfg_unsup), .rd_fill(rd_fill),
    .abort_clr(abort_clr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        vld;
    logic        err;
    logic        unsup;
    logic [31:0] fill;
    logic        clr;
  } exp_t;

  exp_t        eq[$];
  string       tq[$];
  int          total = 0;
  int          bad = 0;
  logic        mon_en = 1'b0;
  logic        done = 1'b0;
  logic [31:0] last_addr = 32'd0;
  logic [31:0] last_fill = 32'd0;

  function automatic exp_t model(input logic wr, input logic [15:0] off,
                                 input logic [2:0] sz, input logic [16:0] map,
                                 input logic [7:0] bus);
    exp_t        e;
    logic [31:0] inter;
    logic [20:0] sel;
    int          dev;
    logic        legal;
    inter = {map[15:0], off};
    sel   = inter[31:11];
    dev   = -1;
    for (int i = 0; i < 21; i++) if (sel[i] && dev < 0) dev = i;
    legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    e = '0;
    e.addr = last_addr;
    if (!legal) begin
      e.err = 1'b1;
    end else if (map[16]) begin
      e.unsup = 1'b1;
      if (!wr) e.fill = (sz == 3'd1) ? 32'h0000_00FF :
                        (sz == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    end else if (dev < 0) begin
      e.err = 1'b1;
    end else begin
      e.vld  = 1'b1;
      e.clr  = 1'b1;
      e.addr = 32'h8000_0000 | ({24'd0, bus} << 16) | (32'(dev) << 11)
             | {21'd0, inter[10:8], 8'd0} | {24'd0, inter[7:2], 2'b00};
    end
    return e;
  endfunction

  task automatic issue(input logic wr, input logic [15:0] off, input logic [2:0] sz,
                       input logic [16:0] map, input logic [7:0] bus, input string tag);
    exp_t e;
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_off = off; acc_size = sz;
    map_cfg = map; bus_num = bus;
    e = model(wr, off, sz, map, bus);
    last_addr = e.addr;
    last_fill = e.fill;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_vld = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : monitor
    exp_t e, a;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (mon_en) begin
        a = {cfg_addr, cfg_vld, cfg_err, cfg_unsup, rd_fill, abort_clr};
        total++;
        if (eq.size() > 0) begin
          e = eq.pop_front();
          t = tq.pop_front();
          if (a !== e) begin
            bad++;
            $display("FAIL %s: addr=%h vld=%b err=%b unsup=%b fill=%h clr=%b expected addr=%h vld=%b err=%b unsup=%b fill=%h clr=%b",
                     t, a.addr, a.vld, a.err, a.unsup, a.fill, a.clr,
                     e.addr, e.vld, e.err, e.unsup, e.fill, e.clr);
          end
        end else begin
          e = '0;
          e.addr = last_addr;
          e.fill = last_fill;
          if (a !== e) begin
            bad++;
            $display("FAIL R3 idle: addr=%h vld=%b err=%b unsup=%b fill=%h clr=%b expected addr=%h fill=%h, pulses low",
                     a.addr, a.vld, a.err, a.unsup, a.fill, a.clr, e.addr, e.fill);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    rst_n = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0; acc_off = '0;
    acc_size = 3'd4; map_cfg = '0; bus_num = '0;
    repeat (4) @(negedge clk);
    total++;
    if ({cfg_addr, cfg_vld, cfg_err, cfg_unsup, rd_fill, abort_clr} !== '0) begin
      bad++;
      $display("FAIL R9 reset: addr=%h vld=%b err=%b unsup=%b fill=%h clr=%b expected all zero",
               cfg_addr, cfg_vld, cfg_err, cfg_unsup, rd_fill, abort_clr);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    idle(2);

    issue(1'b0, 16'h0134, 3'd4, 17'h0_0002, 8'h00, "R1 R2 R7 select from map");
    idle(2);
    issue(1'b1, 16'h1800, 3'd1, 17'h0_0000, 8'h11, "R1 lowest of two offset bits");
    issue(1'b0, 16'h07FF, 3'd2, 17'h0_8000, 8'h5A, "R1 R2 top select bit, low bits dropped");
    issue(1'b0, 16'h0A03, 3'd4, 17'h0_F0F0, 8'hC3, "R1 lowest wins, map bits ignored");
    idle(1);
    issue(1'b0, 16'h07FC, 3'd4, 17'h0_0000, 8'h22, "R6 empty select");
    issue(1'b1, 16'h0000, 3'd2, 17'h0_0000, 8'h22, "R6 empty select write");
    issue(1'b0, 16'h0004, 3'd1, 17'h1_0002, 8'h33, "R4 R5 unsup read size 1");
    issue(1'b0, 16'h0004, 3'd2, 17'h1_0002, 8'h33, "R5 unsup read size 2");
    issue(1'b0, 16'h0004, 3'd4, 17'h1_0002, 8'h33, "R5 unsup read size 4");
    issue(1'b1, 16'h0004, 3'd4, 17'h1_0002, 8'h33, "R4 R5 unsup write dropped");
    idle(2);
    issue(1'b0, 16'h0800, 3'd3, 17'h0_0000, 8'h44, "R8 size 3");
    issue(1'b0, 16'h0800, 3'd0, 17'h1_0000, 8'h44, "R8 size 0 beats unsup");
    issue(1'b0, 16'h0800, 3'd5, 17'h0_0000, 8'h44, "R8 size 5");
    issue(1'b1, 16'h2F7C, 3'd2, 17'h0_0000, 8'h44, "R2 R7 after errors");
    idle(3);
    for (int k = 0; k < 21; k++) begin
      logic [31:0] v;
      v = 32'd1 << (k + 11);
      issue(k[0], v[15:0] | 16'h0254, 3'd4, {1'b0, v[31:16]}, 8'(k * 7), "R1 R2 select sweep");
    end
    issue(1'b0, 16'h0000, 3'd4, 17'h1_0001, 8'h00, "R3 unsup back to back");
    issue(1'b0, 16'h0900, 3'd1, 17'h0_0000, 8'h99, "R3 R7 valid after unsup");
    idle(4);
    mon_en = 1'b0;
    total++;
    if (eq.size() != 0) begin
      bad++;
      $display("FAIL R3 pending results: actual=%0d expected=0", eq.size());
    end
    finish_run();
  end
endmodule